// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates one free-running clock so that a group of loads can be stopped to save power. A stop request `stop_ni` is active low and may change at any time relative to the source clock. It is brought into the clock domain through a chain of flip-flops. A small controller then decides, once per cycle, whether the next high phase of the clock is let through.

The gate enable is held in a latch that is transparent only while the source clock is low. A high phase is therefore either passed whole or suppressed whole. The gated output rests low while stopped. A run counter enforces a minimum number of gated pulses after every restart and after reset. A stop request that arrives earlier is held off until that count is reached. A status output reports when the group is parked.

Top module: `gclk_stop_ctrl`

## Requirements
- R1: `stop_ni` reaches the gating logic only through a synchronizer of `SYNC_STAGES` flip-flops (default 2) clocked by `clk_i`. A level change therefore affects `gclk_o` no earlier than the `SYNC_STAGES + 1`-th rising edge of `clk_i` after it.
- R2: While `stopped_o` is 1, `gclk_o` is 0 for the whole clock period.
- R3: Every high phase of `gclk_o` lasts a full high phase of `clk_i`. No high phase is clipped or shortened.
- R4: Suppose `stop_ni` falls between clock edges after the minimum run count is already met. Then `gclk_o` still issues exactly `SYNC_STAGES` pulses, and the next rising edge of `clk_i` is suppressed.
- R5: Suppose `stop_ni` rises between clock edges while the group is parked. Then the first `gclk_o` pulse comes with the `SYNC_STAGES + 1`-th rising edge of `clk_i` (the 3rd edge by default).
- R6: At least `MIN_RUN` pulses (default 10) are issued after each restart and after reset before the clock stops again. Let c0 be the number of pulses issued since the restart when the request falls. Then the number of further pulses is max(`MIN_RUN` - c0, `SYNC_STAGES`).
- R7: `stopped_o` stays 0 at the first suppressed edge and rises at the edge after it. It falls at the same edge that issues the first restored `gclk_o` pulse.
- R8: During reset (active-low, synchronous) the clock runs even if `stop_ni` is low, and `stopped_o` is 0. Reset clears the run counter, so after reset the full `MIN_RUN` pulses are owed.
- R9: A stop request that is released again before the minimum run count is reached has no effect. `gclk_o` keeps pulsing on every edge and `stopped_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| stop_ni | input | 1 | Asynchronous stop request, active low |
| gclk_o | output | 1 | Gated clock, parked low while stopped |
| stopped_o | output | 1 | High while the gated clock is parked |

## Verification
The assertions assume that `clk_i` runs without pause and that reset is held across at least one rising edge. The exact pulse and latency counts in R4 to R6 also assume that `stop_ni` does not change right at a clock edge. The stimulus meets this by moving `stop_ni` only 1 to 8 ns after a rising edge of a 10 ns clock. It holds a stop request low until the parked state is reached, which keeps the expected tail count well defined. Run lengths, park durations and edge offsets are drawn at random around directed cases: a stop during reset, a stop deferred straight after reset, a short glitch and back-to-back cycles.

// File: rtl/gsc_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock stop controller.
// Assumes: nothing beyond IEEE 1800-2017.
package gsc_pkg;

    // Gate state as seen by the enable latch on the next high phase
    typedef enum logic {
        GATE_OFF = 1'b0,
        GATE_ON  = 1'b1
    } gate_state_e;

    localparam int unsigned DEF_MIN_RUN     = 10;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/gsc_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one asynchronous level.
// Assumes: d_i may change at any time; q_o is valid STAGES edges later.
module gsc_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw asynchronous input
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[i] <= RESET_VAL;
                else         stage_q[i] <= d_i;
            end
        end else begin : g_rest
            // Later flops settle any metastable value
            always_ff @(posedge clk_i) begin
                if (!rst_ni) stage_q[i] <= RESET_VAL;
                else         stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gsc_run_ctrl.sv
`timescale 1ns/1ps
// Decides each cycle whether the next high phase of the clock passes.
// It enforces a minimum count of issued pulses after every restart and
// produces the parked status flag.
// Assumes: stop_req_i is already synchronous to clk_i (active high).
module gsc_run_ctrl
    import gsc_pkg::*;
#(
    parameter int unsigned MIN_RUN = DEF_MIN_RUN
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_req_i,
    output logic gate_en_o,
    output logic stopped_o
);

    localparam int unsigned     CNT_W   = $clog2(MIN_RUN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RUN);

    gate_state_e      state_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic             run_done;
    logic             en_next;
    logic             stopped_q;

    assign run_done = (run_cnt_q == CNT_MAX);

    // Enable for the coming high phase: reset forces run, stops wait for run_done
    always_comb begin
        if (!rst_ni)                 en_next = 1'b1;
        else if (state_q == GATE_ON) en_next = !(stop_req_i && run_done);
        else                         en_next = !stop_req_i;
    end

    // Gate state follows the enable that the latch will present
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= GATE_ON;
        else         state_q <= en_next ? GATE_ON : GATE_OFF;
    end

    // Counts pulses issued since the last restart, saturating at MIN_RUN
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        run_cnt_q <= '0;
        else if (!en_next)  run_cnt_q <= '0;
        else if (!run_done) run_cnt_q <= run_cnt_q + 1'b1;
    end

    // Parked flag: set one edge after the gate closes, cleared on the restart edge
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stopped_q <= 1'b0;
        else         stopped_q <= (state_q == GATE_OFF) && !en_next;
    end

    assign gate_en_o = en_next;
    assign stopped_o = stopped_q;

    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_cnt_q <= CNT_MAX) else $error("run counter overran");                     // R6
    AST_STOP_AFTER_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GATE_OFF) && $past(state_q == GATE_ON) |-> $past(run_cnt_q) == CNT_MAX)
        else $error("stopped before minimum run");                                     // R6
    AST_OFF_PROMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GATE_ON) && stop_req_i && run_done |=> (state_q == GATE_OFF))
        else $error("stop not taken");                                                 // R4
    AST_ON_PROMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == GATE_OFF) && !stop_req_i |=> (state_q == GATE_ON))
        else $error("restart not taken");                                              // R5
    AST_FLAG_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stopped_q |-> (state_q == GATE_OFF)) else $error("flag while running");       // R7

endmodule

// File: rtl/gsc_clk_gate.sv
`timescale 1ns/1ps
// Latch-based clock gate. The enable is taken only while the clock is low,
// so a high phase is always passed or suppressed as a whole.
// Assumes: en_i settles within the low phase of clk_i.
module gsc_clk_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Transparent while the clock is low, holds through the high phase
    always_latch begin
        if (!clk_i) en_lat <= en_i;
    end

    assign gclk_o = clk_i & en_lat;

    // The held enable must never move while the clock is high
    always @(en_lat) begin
        AST_LATCH_HOLD: assert (clk_i !== 1'b1) else $error("enable moved in high phase"); // R3
    end

endmodule

// File: rtl/gclk_stop_ctrl.sv
`timescale 1ns/1ps
// Top of the clock stop controller: synchronizer, run control and gate cell.
// Assumes: clk_i runs freely; stop_ni is asynchronous and active low.
module gclk_stop_ctrl
    import gsc_pkg::*;
#(
    parameter int unsigned MIN_RUN     = DEF_MIN_RUN,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_ni,
    output logic gclk_o,
    output logic stopped_o
);

    logic stop_n_sync;
    logic stop_req;
    logic gate_en;

    gsc_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (stop_ni),
        .q_o   (stop_n_sync)
    );

    assign stop_req = !stop_n_sync;

    gsc_run_ctrl #(
        .MIN_RUN(MIN_RUN)
    ) ctrl_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stop_req_i(stop_req),
        .gate_en_o (gate_en),
        .stopped_o (stopped_o)
    );

    gsc_clk_gate gate_i (
        .clk_i (clk_i),
        .en_i  (gate_en),
        .gclk_o(gclk_o)
    );

    AST_PARK_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
        stopped_o |-> !gclk_o) else $error("gated clock high while parked");          // R2

endmodule

// File: tb/gclk_stop_ctrl_tb_top.sv
`timescale 1ns/1ps
module gclk_stop_ctrl_tb_top;

    localparam int unsigned MIN_RUN = 10;
    localparam int unsigned SYNC    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_n = 1'b1;
    logic gclk;
    logic stopped;

    int checks = 0;
    int fails = 0;
    int unsigned runts = 0;
    int unsigned rise_total = 0;
    int unsigned base = 0;
    bit mon_en = 1'b0;
    realtime t_rise = 0;

    gclk_stop_ctrl #(.MIN_RUN(MIN_RUN), .SYNC_STAGES(SYNC)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n),
        .gclk_o(gclk), .stopped_o(stopped)
    );

    always #5 clk = ~clk;

    // High-phase width monitor (R3) and pulse counter
    always @(posedge gclk) begin
        t_rise = $realtime;
        rise_total++;
    end
    always @(negedge gclk) if (mon_en && ($realtime - t_rise) < 4.5) runts++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulses still issued after a stop request, given c0 pulses since restart
    function automatic int tail_exp(input int c0);
        int need = int'(MIN_RUN) - c0;
        return (need > int'(SYNC)) ? need : int'(SYNC);
    endfunction

    function automatic int on_lat_exp();
        return int'(SYNC) + 1;
    endfunction

    // stop_n has just fallen mid-cycle: count the remaining pulses, check flag timing
    task automatic stop_seq(input int c0);
        int tail = 0;
        forever begin
            @(posedge clk); #1;
            if (gclk) tail++; else break;
            if (tail > int'(MIN_RUN) + 5) break;
        end
        chk(tail == tail_exp(c0), "R4/R6 pulses after stop request", tail, tail_exp(c0));
        chk(stopped == 1'b0, "R7 flag low at first suppressed edge", stopped, 0);
        @(posedge clk); #1;
        chk(stopped == 1'b1 && gclk == 1'b0, "R7 flag high one edge after gate closes", stopped, 1);
    endtask

    // Stay parked for k cycles and check the output is low
    task automatic hold_parked(input int k);
        int bad = 0;
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
            if (gclk !== 1'b0 || stopped !== 1'b1) bad++;
        end
        chk(bad == 0, "R2 output parked low while stopped", bad, 0);
    endtask

    // Release stop mid-cycle, count edges to the first restored pulse
    task automatic restart();
        int n = 0;
        @(posedge clk); #(1 + $urandom % 8);
        base = rise_total;
        stop_n = 1'b1;
        forever begin
            @(posedge clk); n++; #1;
            if (gclk || n > 10) break;
        end
        chk(n == on_lat_exp(), "R1/R5 restart edge count", n, on_lat_exp());
        chk(stopped == 1'b0, "R7 flag low on restored edge", stopped, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int c0;
        void'($urandom(32'd1234));
        // R8: clock runs during reset even with the stop request low
        stop_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(gclk == 1'b1, "R8 clock runs in reset", gclk, 1);
        chk(stopped == 1'b0, "R8 flag low in reset", stopped, 0);
        mon_en = 1'b1;
        // R6 and R8: after reset the full minimum run is owed
        @(posedge clk); #3;
        base = rise_total;
        rst_n = 1'b1;
        stop_seq(0);
        hold_parked(5);
        restart();

        // R9: short glitch before the minimum run is reached is ignored
        @(posedge clk); #(1 + $urandom % 8);
        stop_n = 1'b0;
        @(posedge clk); #(1 + $urandom % 8);
        stop_n = 1'b1;
        begin
            int hi = 0;
            int st = 0;
            for (int i = 0; i < int'(3 * MIN_RUN); i++) begin
                @(posedge clk); #1;
                if (gclk) hi++;
                if (stopped) st++;
            end
            chk(hi == int'(3 * MIN_RUN) && st == 0, "R9 glitch ignored", hi, 3 * MIN_RUN);
        end

        // R4: stop with the minimum run already met
        @(posedge clk); #(1 + $urandom % 8);
        c0 = int'(rise_total - base);
        stop_n = 1'b0;
        stop_seq(c0);
        hold_parked(1);
        restart();

        // Random run lengths, park times and edge offsets
        for (int it = 0; it < 40; it++) begin
            repeat ($urandom % (2 * MIN_RUN)) @(posedge clk);
            @(posedge clk); #(1 + $urandom % 8);
            c0 = int'(rise_total - base);
            stop_n = 1'b0;
            stop_seq(c0);
            hold_parked(int'($urandom % 5));
            restart();
        end

        repeat (4) @(posedge clk);
        chk(runts == 0, "R3 no shortened high phase", runts, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule